// File: doc/BRIEF.md
# 64-bit XGMII Ethernet Receive Framer

This block takes the receive side of a 64-bit XGMII-style link and turns it into a packet stream. Each clock it sees eight data bytes and eight control flags, one of each per lane, with lane 0 first on the wire. It waits for a start word and drops the start character, preamble and delimiter. The bytes between that word and the terminate character then go out on a 64-bit AXI4-Stream with a per-byte keep mask.

The last four bytes before the terminate character are the frame check sequence. The block runs a reflected CRC-32 over every body byte, FCS included, and compares the result with the fixed good-frame residue. The FCS itself never reaches the stream, so the keep mask and tlast of the final beat are set from the lane where the terminate character landed. A frame with a wrong FCS, and a frame that is malformed, each end with tuser high on the last beat and one pulse on its own error output.

The block has no buffer. The stream cannot stall the line. A body beat that the sink refuses is lost, and the frame is then reported as malformed.

Top module: `xgmii_rx_framer`

## Requirements
- R1: After reset, tvalid, crc_bad and frame_bad are low. Idle words (0x07 in every lane with every control flag set) produce no beat and no pulse.
- R2: A frame starts on a word with 0xFB in lane 0, control flag 0 set and flags 1 to 7 clear, 0x55 in lanes 1 to 6 and 0xD5 in lane 7. No byte of this word is output. The first body byte appears in lane 0 of the first beat.
- R3: Body bytes leave in wire order, lane i of the stream carrying tdata bits 8i+7 to 8i. Every beat except the last has tkeep 0xFF, tlast low and tuser low.
- R4: The frame ends at the lowest lane k that holds 0xFD with its control flag set. The last beat keeps lanes 0 to n-1 only (tkeep bit i set for lane i), where n = L mod 8, or 8 when L is a multiple of 8, and L is the number of body bytes minus four. When k is 4 or below, the final beat is the word before the terminate word.
- R5: The CRC uses reflected polynomial 0x04C11DB7 with seed 0xFFFFFFFF and no final inversion, run over all body bytes including the FCS. A residue of 0xDEBB20E3 marks a good frame: its last beat has tuser low and no pulse follows.
- R6: Any other residue sets tuser on the last beat and raises crc_bad for exactly the cycle in which that beat is valid.
- R7: A control flag set in a lane below the terminate lane (for example 0xFE), or in any lane of a body word with no terminate, ends the frame at once. The previous word, if any, goes out as the last beat with tkeep 0xFF and tuser high, and frame_bad pulses. Words after that are ignored until the next start word.
- R8: A start character in lane 0 whose following bytes are not the exact preamble and delimiter gives one frame_bad pulse and no beat.
- R9: A frame that ends before any payload byte (terminate at lane 4 or below in the first body word) gives one frame_bad pulse and no beat.
- R10: A bad frame raises exactly one pulse. frame_bad takes precedence, so crc_bad never pulses together with frame_bad.
- R11: A non-final beat offered while tready is low is lost. The frame's remaining last beat carries tuser high and frame_bad pulses.
- R12: A start word in the cycle right after a terminate word begins a new frame without losing either frame's beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the line and the stream |
| rst | input | 1 | Synchronous active-high reset |
| xg_rxd | input | 64 | Received data, lane i in bits 8i+7..8i |
| xg_rxc | input | 8 | Received control flags, one per lane |
| m_tdata | output | 64 | Stream data |
| m_tkeep | output | 8 | Stream byte keep, bit i for lane i |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Sink accepts the beat |
| m_tlast | output | 1 | Last beat of a frame |
| m_tuser | output | 1 | Frame is bad (set on the last beat only) |
| crc_bad | output | 1 | One-cycle pulse: FCS mismatch |
| frame_bad | output | 1 | One-cycle pulse: malformed frame |

## Verification
The in-RTL properties check on every cycle the shape of the stream and of the pulses. Non-final beats are full and clean. The keep mask is contiguous from lane 0. crc_bad only ever comes with a flagged last beat, and the two pulses never coincide. Whether the bytes are the right ones can only be seen in the bench scenarios. Those cover the terminate character in each of the eight lanes, the FCS split across two words, corrupted FCS, error characters, bad preambles, empty frames, a refused beat and back-to-back frames, each checked against a frame whose CRC the bench computes itself.

// File: rtl/xgrx_pkg.sv
`timescale 1ns/1ps
package xgrx_pkg;
    localparam int LANES     = 8;
    localparam int DW        = LANES * 8;
    localparam int LW        = $clog2(LANES + 1);
    localparam int FCS_BYTES = 4;

    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] BY_PRE   = 8'h55;
    localparam logic [7:0] BY_SFD   = 8'hD5;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_GOOD      = 32'hDEBB20E3;

    typedef enum logic {S_WAIT, S_BODY} rx_state_e;

    typedef struct packed {
        logic             vld;
        logic [DW-1:0]    data;
        logic [LANES-1:0] keep;
        logic             last;
        logic             user;
        logic             crc_err;
        logic             frm_err;
    } beat_t;

    // mask with the n lowest lanes set
    function automatic logic [LANES-1:0] keep_lo(input logic [LW-1:0] n);
        keep_lo = '0;
        for (int i = 0; i < LANES; i++)
            if (i < int'(n)) keep_lo[i] = 1'b1;
    endfunction
endpackage

// File: rtl/xgrx_lane_scan.sv
`timescale 1ns/1ps
module xgrx_lane_scan
    import xgrx_pkg::*;
(
    input  logic [DW-1:0]    d,
    input  logic [LANES-1:0] c,
    output logic             term_hit,
    output logic [LW-1:0]    term_lane,
    output logic             ctl_err,
    output logic             sof,
    output logic             pre_ok
);
    always_comb begin
        term_hit  = 1'b0;
        term_lane = LW'(LANES);
        // lowest lane holding a terminate wins
        for (int i = LANES - 1; i >= 0; i--) begin
            if (c[i] && d[8*i +: 8] == CH_TERM) begin
                term_hit  = 1'b1;
                term_lane = LW'(i);
            end
        end
        // any control flag ahead of the terminate (or anywhere without one)
        ctl_err = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (c[i] && i < int'(term_lane)) ctl_err = 1'b1;

        sof    = c[0] && d[7:0] == CH_START;
        pre_ok = (c[LANES-1:1] == '0) && (d[DW-1 -: 8] == BY_SFD);
        for (int i = 1; i < LANES - 1; i++)
            if (d[8*i +: 8] != BY_PRE) pre_ok = 1'b0;
    end
endmodule

// File: rtl/xgrx_crc.sv
`timescale 1ns/1ps
module xgrx_crc
    import xgrx_pkg::*;
#(
    parameter int NB = LANES,
    localparam int NBW = $clog2(NB + 1)
) (
    input  logic [31:0]     crc_in,
    input  logic [8*NB-1:0] data,
    input  logic [NBW-1:0]  nbytes,
    output logic [31:0]     crc_out
);
    // bytes 0..nbytes-1, lane 0 first, bits LSB first
    always_comb begin
        crc_out = crc_in;
        for (int b = 0; b < NB; b++) begin
            if (b < int'(nbytes)) begin
                for (int k = 0; k < 8; k++) begin
                    crc_out = {1'b0, crc_out[31:1]}
                            ^ ((crc_out[0] ^ data[8*b + k]) ? CRC_POLY_REFL : 32'h0);
                end
            end
        end
    end
endmodule

// File: rtl/xgmii_rx_framer.sv
`timescale 1ns/1ps
module xgmii_rx_framer
    import xgrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    xg_rxd,
    input  logic [LANES-1:0] xg_rxc,
    output logic [DW-1:0]    m_tdata,
    output logic [LANES-1:0] m_tkeep,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic             m_tlast,
    output logic             m_tuser,
    output logic             crc_bad,
    output logic             frame_bad
);
    rx_state_e     st_q, st_d;
    logic          hold_vld_q, hold_vld_d;
    logic [DW-1:0] hold_q, hold_d;
    logic [31:0]   crc_q, crc_d, crc_next;
    logic          lost_q, lost_d;
    beat_t         pend_q, pend_d, out_q, out_d;

    logic          term_hit, ctl_err, sof, pre_ok;
    logic [LW-1:0] term_lane, crc_nb;
    logic          drop_now, lost, fcs_bad;

    xgrx_lane_scan u_scan (
        .d(xg_rxd), .c(xg_rxc),
        .term_hit(term_hit), .term_lane(term_lane), .ctl_err(ctl_err),
        .sof(sof), .pre_ok(pre_ok)
    );

    assign crc_nb = term_hit ? term_lane : LW'(LANES);

    xgrx_crc #(.NB(LANES)) u_crc (
        .crc_in(crc_q), .data(xg_rxd), .nbytes(crc_nb), .crc_out(crc_next)
    );

    always_comb begin
        st_d       = st_q;
        hold_vld_d = hold_vld_q;
        hold_d     = hold_q;
        crc_d      = crc_q;
        pend_d     = '0;
        out_d      = '0;
        drop_now   = out_q.vld & ~out_q.last & ~m_tready;
        lost       = lost_q | drop_now;
        lost_d     = lost;
        fcs_bad    = crc_next != CRC_GOOD;

        // deferred last beat from a terminate in a high lane
        if (pend_q.vld) begin
            out_d         = pend_q;
            out_d.frm_err = pend_q.frm_err | lost;
            out_d.crc_err = pend_q.crc_err & ~out_d.frm_err;
            out_d.user    = out_d.frm_err | out_d.crc_err;
        end

        unique case (st_q)
            S_WAIT: begin
                if (sof) begin
                    if (pre_ok) begin
                        st_d       = S_BODY;
                        crc_d      = CRC_SEED;
                        hold_vld_d = 1'b0;
                        lost_d     = 1'b0;
                    end else begin
                        out_d.frm_err = 1'b1;
                        out_d.crc_err = 1'b0;
                    end
                end
            end
            S_BODY: begin
                if (ctl_err) begin
                    st_d          = S_WAIT;
                    hold_vld_d    = 1'b0;
                    out_d.frm_err = 1'b1;
                    if (hold_vld_q) begin
                        out_d.vld  = 1'b1;
                        out_d.data = hold_q;
                        out_d.keep = '1;
                        out_d.last = 1'b1;
                        out_d.user = 1'b1;
                    end
                end else if (!term_hit) begin
                    crc_d      = crc_next;
                    hold_d     = xg_rxd;
                    hold_vld_d = 1'b1;
                    if (hold_vld_q) begin
                        out_d.vld  = 1'b1;
                        out_d.data = hold_q;
                        out_d.keep = '1;
                    end
                end else begin
                    st_d       = S_WAIT;
                    hold_vld_d = 1'b0;
                    if (term_lane > LW'(FCS_BYTES)) begin
                        // payload bytes remain in the terminate word
                        if (hold_vld_q) begin
                            out_d.vld  = 1'b1;
                            out_d.data = hold_q;
                            out_d.keep = '1;
                        end
                        pend_d.vld     = 1'b1;
                        pend_d.data    = xg_rxd;
                        pend_d.keep    = keep_lo(term_lane - LW'(FCS_BYTES));
                        pend_d.last    = 1'b1;
                        pend_d.crc_err = fcs_bad;
                        pend_d.frm_err = lost;
                    end else if (hold_vld_q) begin
                        // FCS reaches back into the held word
                        out_d.vld     = 1'b1;
                        out_d.data    = hold_q;
                        out_d.keep    = keep_lo(term_lane + LW'(FCS_BYTES));
                        out_d.last    = 1'b1;
                        out_d.frm_err = lost;
                        out_d.crc_err = fcs_bad & ~lost;
                        out_d.user    = lost | fcs_bad;
                    end else begin
                        out_d.frm_err = 1'b1;
                    end
                end
            end
            default: st_d = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_WAIT;
            hold_vld_q <= 1'b0;
            hold_q     <= '0;
            crc_q      <= CRC_SEED;
            lost_q     <= 1'b0;
            pend_q     <= '0;
            out_q      <= '0;
        end else begin
            st_q       <= st_d;
            hold_vld_q <= hold_vld_d;
            hold_q     <= hold_d;
            crc_q      <= crc_d;
            lost_q     <= lost_d;
            pend_q     <= pend_d;
            out_q      <= out_d;
        end
    end

    assign m_tdata   = out_q.data;
    assign m_tkeep   = out_q.keep;
    assign m_tvalid  = out_q.vld;
    assign m_tlast   = out_q.last;
    assign m_tuser   = out_q.user;
    assign crc_bad   = out_q.crc_err;
    assign frame_bad = out_q.frm_err;

    // R10
    pulses_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(crc_bad && frame_bad));

    // R6
    crc_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        crc_bad |-> (m_tvalid && m_tlast && m_tuser));

    // R3
    mid_beat_full_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tlast) |-> (m_tkeep == '1 && !m_tuser));

    // R4
    keep_contig_chk: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tkeep[0] && ((m_tkeep & (m_tkeep + 8'd1)) == '0)));
endmodule

// File: tb/xgmii_rx_framer_test.sv
`timescale 1ns/1ps
module xgmii_rx_framer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] xg_rxd = 64'h0707070707070707;
    logic [7:0]  xg_rxc = 8'hFF;
    logic [63:0] m_tdata;
    logic [7:0]  m_tkeep;
    logic        m_tvalid, m_tlast, m_tuser, crc_bad, frame_bad;
    logic        m_tready = 1'b1;

    localparam logic [63:0] IDLE_W = 64'h0707070707070707;

    always #2.5 clk = ~clk;

    xgmii_rx_framer uut (
        .clk(clk), .rst(rst), .xg_rxd(xg_rxd), .xg_rxc(xg_rxc),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast), .m_tuser(m_tuser),
        .crc_bad(crc_bad), .frame_bad(frame_bad)
    );

    int n_run = 0, n_bad = 0;

    // {len[15:8], mode[7:6], err_pos[5:0]}; mode 0 good, 1 bad FCS, 2 error char, 3 bad preamble
    localparam int NV = 18;
    localparam logic [15:0] VEC [NV] = '{
        {8'd1, 2'd0, 6'd0},  {8'd2, 2'd0, 6'd0},  {8'd3, 2'd0, 6'd0},
        {8'd4, 2'd0, 6'd0},  {8'd5, 2'd0, 6'd0},  {8'd7, 2'd0, 6'd0},
        {8'd8, 2'd0, 6'd0},  {8'd12, 2'd0, 6'd0}, {8'd13, 2'd0, 6'd0},
        {8'd16, 2'd0, 6'd0}, {8'd27, 2'd0, 6'd0}, {8'd60, 2'd0, 6'd0},
        {8'd20, 2'd1, 6'd0}, {8'd9, 2'd1, 6'd0},  {8'd0, 2'd0, 6'd0},
        {8'd30, 2'd2, 6'd12},{8'd10, 2'd2, 6'd3}, {8'd16, 2'd3, 6'd0}
    };

    logic [63:0] got_d [32];
    logic [7:0]  got_k [32];
    logic        got_l [32];
    logic        got_u [32];
    int          got_n, got_crc, got_frm, got_misal;
    logic [63:0] exp_d [32];
    logic [7:0]  exp_k [32];
    logic        exp_l [32];
    logic        exp_u [32];
    int          exp_n, exp_crc, exp_frm;
    logic [7:0]  fr [128];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] expv);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic clear_all();
        got_n = 0; got_crc = 0; got_frm = 0; got_misal = 0;
        exp_n = 0; exp_crc = 0; exp_frm = 0;
    endtask

    // drive one word; the beat visible now is accepted at the next edge when rdy is high
    task automatic step(input logic [63:0] d, input logic [7:0] c, input logic rdy);
        @(negedge clk);
        xg_rxd   = d;
        xg_rxc   = c;
        m_tready = rdy;
        if (m_tvalid && rdy && got_n < 32) begin
            logic [63:0] dm;
            for (int j = 0; j < 8; j++) dm[8*j +: 8] = m_tkeep[j] ? m_tdata[8*j +: 8] : 8'h00;
            got_d[got_n] = dm;
            got_k[got_n] = m_tkeep;
            got_l[got_n] = m_tlast;
            got_u[got_n] = m_tuser;
            got_n++;
        end
        if (crc_bad) got_crc++;
        if (frame_bad) got_frm++;
        if (crc_bad && !(m_tvalid && m_tlast)) got_misal++;
    endtask

    task automatic send_frame(input int len, input int mode, input int epos,
                              input int drop_w, input int gap);
        logic [31:0] c;
        logic [63:0] d;
        logic [7:0]  cw;
        int tot, nw, nb, kc;
        bit malformed;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            fr[i] = 8'(i * 29 + len * 3 + 5);
            for (int k = 0; k < 8; k++)
                c = (c >> 1) ^ ((c[0] ^ fr[i][k]) ? 32'hEDB88320 : 32'h0);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) fr[len + i] = c[8*i +: 8];
        if (mode == 1) fr[len] = fr[len] ^ 8'h01;
        tot = len + 4;

        d = 64'hD5555555555555FB;
        if (mode == 3) d[31:24] = 8'h54;
        step(d, 8'h01, 1'b1);
        nw = tot / 8 + 1;
        for (int w = 0; w < nw; w++) begin
            for (int j = 0; j < 8; j++) begin
                int idx;
                idx = 8 * w + j;
                if (mode == 2 && idx == epos) begin d[8*j +: 8] = 8'hFE; cw[j] = 1'b1; end
                else if (idx < tot)        begin d[8*j +: 8] = fr[idx]; cw[j] = 1'b0; end
                else if (idx == tot)       begin d[8*j +: 8] = 8'hFD; cw[j] = 1'b1; end
                else                       begin d[8*j +: 8] = 8'h07; cw[j] = 1'b1; end
            end
            step(d, cw, (w == drop_w) ? 1'b0 : 1'b1);
        end
        for (int g = 0; g < gap; g++) step(IDLE_W, 8'hFF, 1'b1);

        // expectation from the requirements
        malformed = (mode >= 2) || (len == 0) || (drop_w >= 2);
        if (mode == 3)      nb = 0;
        else if (mode == 2) nb = epos / 8;
        else                nb = (len + 7) / 8;
        for (int b = 0; b < nb; b++) begin
            if (drop_w >= 2 && b == drop_w - 2) continue;
            kc = (mode == 2 || b < nb - 1) ? 8 : len - 8 * (nb - 1);
            exp_d[exp_n] = '0;
            exp_k[exp_n] = '0;
            for (int j = 0; j < kc; j++) begin
                exp_d[exp_n][8*j +: 8] = fr[8*b + j];
                exp_k[exp_n][j] = 1'b1;
            end
            exp_l[exp_n] = (b == nb - 1);
            exp_u[exp_n] = (b == nb - 1) && (malformed || mode == 1);
            exp_n++;
        end
        if (malformed) exp_frm++;
        else if (mode == 1) exp_crc++;
    endtask

    task automatic compare(input string req);
        chk(got_n == exp_n, req, "beat count", 80'(got_n), 80'(exp_n));
        for (int b = 0; b < exp_n && b < got_n; b++)
            chk({got_d[b], got_k[b], got_l[b], got_u[b]} == {exp_d[b], exp_k[b], exp_l[b], exp_u[b]},
                req, "beat {data,keep,last,user}",
                {6'd0, got_d[b], got_k[b], got_l[b], got_u[b]},
                {6'd0, exp_d[b], exp_k[b], exp_l[b], exp_u[b]});
        // R10: one pulse per bad frame, on the right line
        chk(got_frm == exp_frm, req, "R10 frame_bad pulses", 80'(got_frm), 80'(exp_frm));
        chk(got_crc == exp_crc, req, "R10 crc_bad pulses", 80'(got_crc), 80'(exp_crc));
        // R6: crc pulse coincides with the last beat
        chk(got_misal == 0, req, "R6 crc_bad off last beat", 80'(got_misal), 80'd0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!m_tvalid && !crc_bad && !frame_bad, "R1", "outputs in reset",
            80'({m_tvalid, crc_bad, frame_bad}), 80'd0);
        rst = 1'b0;
        clear_all();
        for (int i = 0; i < 6; i++) step(IDLE_W, 8'hFF, 1'b1);
        chk(got_n == 0 && got_frm == 0 && got_crc == 0, "R1", "idle beats/pulses",
            80'(got_n + got_frm + got_crc), 80'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            int len, mode, epos;
            string tag;
            len  = int'(VEC[v][15:8]);
            mode = int'(VEC[v][7:6]);
            epos = int'(VEC[v][5:0]);
            case (mode)
                1: tag = "R6";
                2: tag = "R7";
                3: tag = "R8";
                default: tag = (len == 0) ? "R9" : "R4";
            endcase
            clear_all();
            send_frame(len, mode, epos, -1, 3);
            compare(tag);
        end

        // R2 and R3: first payload byte in lane 0, body in order, clean good frame (R5)
        clear_all();
        send_frame(21, 0, 0, -1, 3);
        chk(got_n > 0 && got_d[0][7:0] == fr[0], "R2", "first byte lane 0",
            80'(got_n > 0 ? got_d[0][7:0] : 8'h00), 80'(fr[0]));
        compare("R3");
        chk(got_n == 3 && !got_u[2] && got_crc == 0, "R5", "good frame unflagged",
            80'({got_u[2], 8'(got_crc)}), 80'd0);

        // R11: middle beat refused
        clear_all();
        send_frame(30, 0, 0, 2, 3);
        compare("R11");

        // R12: back-to-back frames, second start right after terminate in lane 7
        clear_all();
        send_frame(11, 0, 0, -1, 0);
        send_frame(9, 0, 0, -1, 3);
        compare("R12");

        // R7: trailing words after an abort are ignored before a good frame
        clear_all();
        send_frame(24, 2, 9, -1, 0);
        send_frame(6, 0, 0, -1, 3);
        compare("R7");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule